// File: doc/BRIEF.md
# Fractional-Rate Time-of-Day Counter

This block keeps a precise time of day for stamping packets. On every clock it adds a programmable step to a nanoseconds register. That register holds 30 integer bits and 8 fraction bits, so the lowest bit is 1/256 ns. When the sum reaches or passes a programmable wrap value, the wrap value is subtracted and a 48-bit seconds register counts up in the same cycle. The step is given with a 32-bit nanosecond fraction. The upper 8 fraction bits are added directly. The lower 24 bits feed a first-order delta-sigma accumulator, whose carry adds one LSB now and then, so the long-run rate matches the programmed period exactly.

Control software has three one-cycle strobes:
- Load a new nominal period.
- Overwrite the seconds and nanoseconds registers with an absolute time.
- Start a slew: a signed-free extra offset, in the same 8.32 format as the period, is added on top of the period for a counted number of cycles. This shifts the time by a fixed amount without changing the nominal rate.

Top module: `tod_counter`

## Requirements
- R1: A synchronous active-high reset clears the seconds, the nanoseconds, the period, the offset and the slew count. After reset, and as long as no period has been loaded, both outputs stay at zero.
- R2: On a clock edge where `period_ld` is high, `period_in` is latched. The period is 8 integer ns in bits 39:32 and a 32-bit fraction in bits 31:0. The edge that latches it still adds the old period. Every later edge adds the new one, until the next load.
- R3: The nanoseconds output `tod_ns` has integer ns in bits 37:8 and a 1/256 ns fraction in bits 7:0. When `tod_ns` plus the step is equal to or greater than `wrap_ns` (same format), the next value is that sum minus `wrap_ns`, and `tod_sec` increases by one on the same edge.
- R4: On an edge where `time_ld` is high, `tod_sec` takes `time_sec_in` and `tod_ns` takes `time_ns_in`. The load replaces any increment that would have happened on that edge.
- R5: Period fraction bits 31:24 are added as the 8 fraction bits of the step. Bits 23:0 are summed in a 24-bit accumulator, and each carry out of that accumulator adds one 1/256 ns LSB on the same edge. A low part of 0x800000 therefore adds one extra LSB on every second edge.
- R6: On an edge where `adj_ld` is high, `adj_offset` (8.32 format) and `adj_cycles` are latched, and no offset is added on that edge. On each of the next `adj_cycles` edges, the offset is added on top of the period. The total extra advance equals the offset times the count.
- R7: An `adj_ld` strobe while a slew is still running discards the remaining count and the old offset. The old offset is still applied on the strobe edge itself. From the following edge on, the new pair is in effect.
- R8: An `adj_ld` strobe with `adj_cycles` equal to zero adds no extra advance at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_ld | input | 1 | One-cycle strobe: latch a new period |
| period_in | input | 40 | Period, 8 integer ns and 32 fraction bits |
| adj_ld | input | 1 | One-cycle strobe: start a slew |
| adj_offset | input | 40 | Slew offset per cycle, same format as the period |
| adj_cycles | input | 32 | Number of cycles the offset is applied |
| time_ld | input | 1 | One-cycle strobe: overwrite the time |
| time_ns_in | input | 38 | Nanoseconds value to load, 30.8 format |
| time_sec_in | input | 48 | Seconds value to load |
| wrap_ns | input | 38 | Nanoseconds wrap value, 30.8 format |
| tod_ns | output | 38 | Current nanoseconds, 30.8 format |
| tod_sec | output | 48 | Current seconds |

## Verification
The bench builds the block with its default parameters: a 30.8 nanoseconds register, an 8.32 period and offset, 48-bit seconds and a 32-bit slew count. With these defaults the delta-sigma path is generated, not the direct one. The wrap input is driven with one second for the boundary loads near the top of the second, including the exact-equality wrap. It is then lowered to one microsecond, so a few hundred cycles go through many seconds carries, with periods that divide the wrap and periods that do not. Period fractions with a low part of 0x800000 give a predictable every-other-cycle carry, which makes the average-rate result exact.

// File: rtl/tod_pkg.sv
package tod_pkg;
   localparam int unsigned TOD_NS_INT_W   = 30;
   localparam int unsigned TOD_NS_FRAC_W  = 8;
   localparam int unsigned TOD_SEC_W      = 48;
   localparam int unsigned TOD_PER_INT_W  = 8;
   localparam int unsigned TOD_PER_FRAC_W = 32;
   localparam int unsigned TOD_CNT_W      = 32;

   // one second expressed in the fixed-point nanosecond format
   function automatic longint unsigned tod_second_fixed(int unsigned frac_w);
      return 64'd1_000_000_000 << frac_w;
   endfunction
endpackage

// File: rtl/tod_step_gen.sv
// Holds the nominal period and the slew offset/count; produces the raw step.
module tod_step_gen #(
   parameter int unsigned PER_W = 40,
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             per_ld,
   input  logic [PER_W-1:0] per_in,
   input  logic             adj_ld,
   input  logic [PER_W-1:0] adj_off,
   input  logic [CNT_W-1:0] adj_cnt,
   output logic [PER_W:0]   step,
   output logic [PER_W-1:0] per_q,
   output logic [CNT_W-1:0] cnt_q
);
   logic [PER_W-1:0] off_q;
   logic             slewing;

   assign slewing = (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         per_q <= '0;
      end else if (per_ld) begin
         per_q <= per_in;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         off_q <= '0;
         cnt_q <= '0;
      end else if (adj_ld) begin
         off_q <= adj_off;
         cnt_q <= adj_cnt;
      end else if (slewing) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   always_comb begin
      step = {1'b0, per_q};
      if (slewing) begin
         step = {1'b0, per_q} + {1'b0, off_q};
      end
   end
endmodule

// File: rtl/tod_rate_reducer.sv
// Reduces the wide step fraction to the stored fraction width.
module tod_rate_reducer #(
   parameter int unsigned PER_W = 40,
   parameter int unsigned DS_W  = 24,
   parameter int unsigned INC_W = PER_W - DS_W + 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PER_W:0]   step,
   output logic [INC_W-1:0] inc
);
   if (INC_W != PER_W - DS_W + 2) begin : g_bad_inc
      $error("tod_rate_reducer: INC_W must equal PER_W-DS_W+2");
   end

   if (DS_W > 0) begin : g_delta_sigma
      logic [DS_W-1:0] acc_q;
      logic [DS_W:0]   acc_sum;
      logic            carry;

      assign acc_sum = {1'b0, acc_q} + {1'b0, step[DS_W-1:0]};
      assign carry   = acc_sum[DS_W];
      assign inc     = {1'b0, step[PER_W:DS_W]} + {{(INC_W-1){1'b0}}, carry};

      always_ff @(posedge clk) begin
         if (rst) begin
            acc_q <= '0;
         end else begin
            acc_q <= acc_sum[DS_W-1:0];
         end
      end
   end else begin : g_direct
      assign inc = {1'b0, step};
   end
endmodule

// File: rtl/tod_accum.sv
// Nanoseconds accumulator with wrap and seconds carry; load path has priority.
module tod_accum #(
   parameter int unsigned NS_W  = 38,
   parameter int unsigned SEC_W = 48,
   parameter int unsigned INC_W = 18
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             time_ld,
   input  logic [NS_W-1:0]  ld_ns,
   input  logic [SEC_W-1:0] ld_sec,
   input  logic [NS_W-1:0]  wrap,
   input  logic [INC_W-1:0] inc,
   output logic [NS_W-1:0]  ns_q,
   output logic [SEC_W-1:0] sec_q
);
   localparam int unsigned PAD_W = NS_W + 1 - INC_W;

   if (INC_W >= NS_W + 1) begin : g_bad_width
      $error("tod_accum: increment must be narrower than the ns register");
   end

   logic [NS_W:0]   ns_sum;
   logic [NS_W:0]   ns_wrapped;
   logic            at_wrap;
   logic [NS_W-1:0] ns_next;

   assign ns_sum     = {1'b0, ns_q} + {{PAD_W{1'b0}}, inc};
   assign at_wrap    = (ns_sum >= {1'b0, wrap});
   assign ns_wrapped = ns_sum - {1'b0, wrap};
   assign ns_next    = at_wrap ? ns_wrapped[NS_W-1:0] : ns_sum[NS_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         ns_q  <= '0;
         sec_q <= '0;
      end else if (time_ld) begin
         ns_q  <= ld_ns;
         sec_q <= ld_sec;
      end else begin
         ns_q <= ns_next;
         if (at_wrap) begin
            sec_q <= sec_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
   import tod_pkg::*;
#(
   parameter int unsigned NS_INT_W   = TOD_NS_INT_W,
   parameter int unsigned NS_FRAC_W  = TOD_NS_FRAC_W,
   parameter int unsigned SEC_W      = TOD_SEC_W,
   parameter int unsigned PER_INT_W  = TOD_PER_INT_W,
   parameter int unsigned PER_FRAC_W = TOD_PER_FRAC_W,
   parameter int unsigned CNT_W      = TOD_CNT_W,
   localparam int unsigned NS_W      = NS_INT_W + NS_FRAC_W,
   localparam int unsigned PER_W     = PER_INT_W + PER_FRAC_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             period_ld,
   input  logic [PER_W-1:0] period_in,
   input  logic             adj_ld,
   input  logic [PER_W-1:0] adj_offset,
   input  logic [CNT_W-1:0] adj_cycles,
   input  logic             time_ld,
   input  logic [NS_W-1:0]  time_ns_in,
   input  logic [SEC_W-1:0] time_sec_in,
   input  logic [NS_W-1:0]  wrap_ns,
   output logic [NS_W-1:0]  tod_ns,
   output logic [SEC_W-1:0] tod_sec
);
   localparam int unsigned DS_W  = PER_FRAC_W - NS_FRAC_W;
   localparam int unsigned INC_W = PER_W - DS_W + 2;

   if (PER_FRAC_W < NS_FRAC_W) begin : g_bad_frac
      $error("tod_counter: period fraction narrower than stored fraction");
   end
   if (PER_INT_W >= NS_INT_W) begin : g_bad_int
      $error("tod_counter: period integer part must be narrower than ns register");
   end
   if (CNT_W < 1 || SEC_W < 1) begin : g_bad_cnt
      $error("tod_counter: counter widths must be positive");
   end

   logic [PER_W:0]   step;
   logic [PER_W-1:0] per_q;
   logic [CNT_W-1:0] slew_cnt;
   logic [INC_W-1:0] inc;

   tod_step_gen #(
      .PER_W (PER_W),
      .CNT_W (CNT_W)
   ) u_step (
      .clk     (clk),
      .rst     (rst),
      .per_ld  (period_ld),
      .per_in  (period_in),
      .adj_ld  (adj_ld),
      .adj_off (adj_offset),
      .adj_cnt (adj_cycles),
      .step    (step),
      .per_q   (per_q),
      .cnt_q   (slew_cnt)
   );

   tod_rate_reducer #(
      .PER_W (PER_W),
      .DS_W  (DS_W),
      .INC_W (INC_W)
   ) u_reduce (
      .clk  (clk),
      .rst  (rst),
      .step (step),
      .inc  (inc)
   );

   tod_accum #(
      .NS_W  (NS_W),
      .SEC_W (SEC_W),
      .INC_W (INC_W)
   ) u_accum (
      .clk     (clk),
      .rst     (rst),
      .time_ld (time_ld),
      .ld_ns   (time_ns_in),
      .ld_sec  (time_sec_in),
      .wrap    (wrap_ns),
      .inc     (inc),
      .ns_q    (tod_ns),
      .sec_q   (tod_sec)
   );
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
   parameter int unsigned NS_W  = 38,
   parameter int unsigned SEC_W = 48,
   parameter int unsigned PER_W = 40,
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst,
   input logic             period_ld,
   input logic [PER_W-1:0] period_in,
   input logic             adj_ld,
   input logic [CNT_W-1:0] adj_cycles,
   input logic             time_ld,
   input logic [NS_W-1:0]  time_ns_in,
   input logic [SEC_W-1:0] time_sec_in,
   input logic [PER_W-1:0] per_q,
   input logic [CNT_W-1:0] slew_cnt,
   input logic [NS_W-1:0]  tod_ns,
   input logic [SEC_W-1:0] tod_sec
);
   logic rst_seen;

   always_ff @(posedge clk) rst_seen <= rst;

   always @(negedge clk) begin
      if (rst_seen) begin
         p_reset_clear_r1: assert (tod_ns == '0 && tod_sec == '0)
            else $error("outputs not cleared by reset");
      end
   end

   p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
      (per_q == '0 && slew_cnt == '0 && !time_ld) |=> ($stable(tod_ns) && $stable(tod_sec)));

   p_period_load_r2: assert property (@(posedge clk) disable iff (rst)
      period_ld |=> (per_q == $past(period_in)));

   p_period_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !period_ld |=> $stable(per_q));

   p_sec_step_r3: assert property (@(posedge clk) disable iff (rst)
      !time_ld |=> (tod_sec == $past(tod_sec) || tod_sec == $past(tod_sec) + 1'b1));

   p_time_load_r4: assert property (@(posedge clk) disable iff (rst)
      time_ld |=> (tod_ns == $past(time_ns_in) && tod_sec == $past(time_sec_in)));

   p_slew_count_r6: assert property (@(posedge clk) disable iff (rst)
      (!adj_ld && slew_cnt != '0) |=> (slew_cnt == $past(slew_cnt) - 1'b1));

   p_slew_replace_r7: assert property (@(posedge clk) disable iff (rst)
      adj_ld |=> (slew_cnt == $past(adj_cycles)));
endmodule

bind tod_counter tod_counter_chk #(
   .NS_W  (NS_W),
   .SEC_W (SEC_W),
   .PER_W (PER_W),
   .CNT_W (CNT_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .period_ld   (period_ld),
   .period_in   (period_in),
   .adj_ld      (adj_ld),
   .adj_cycles  (adj_cycles),
   .time_ld     (time_ld),
   .time_ns_in  (time_ns_in),
   .time_sec_in (time_sec_in),
   .per_q       (per_q),
   .slew_cnt    (slew_cnt),
   .tod_ns      (tod_ns),
   .tod_sec     (tod_sec)
);

// File: tb/sim_tod_counter.sv
`timescale 1ns/1ps
module sim_tod_counter;
   localparam longint unsigned NSEC = 64'd1_000_000_000;
   localparam longint unsigned LSB  = 64'd256;   // raw units per ns

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        period_ld = 1'b0;
   logic [39:0] period_in = '0;
   logic        adj_ld = 1'b0;
   logic [39:0] adj_offset = '0;
   logic [31:0] adj_cycles = '0;
   logic        time_ld = 1'b0;
   logic [37:0] time_ns_in = '0;
   logic [47:0] time_sec_in = '0;
   logic [37:0] wrap_ns = 38'(NSEC * LSB);
   logic [37:0] tod_ns;
   logic [47:0] tod_sec;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      longint unsigned ns;
      longint unsigned sec;
   } exp_t;
   exp_t sb_q[$];

   always #2 clk = ~clk;

   tod_counter u0 (
      .clk(clk), .rst(rst),
      .period_ld(period_ld), .period_in(period_in),
      .adj_ld(adj_ld), .adj_offset(adj_offset), .adj_cycles(adj_cycles),
      .time_ld(time_ld), .time_ns_in(time_ns_in), .time_sec_in(time_sec_in),
      .wrap_ns(wrap_ns), .tod_ns(tod_ns), .tod_sec(tod_sec)
   );

   task automatic chk(input string tag, input longint unsigned act_ns, input longint unsigned act_sec,
                      input longint unsigned exp_ns, input longint unsigned exp_sec);
      checks++;
      if (act_ns != exp_ns || act_sec != exp_sec) begin
         failures++;
         $display("FAIL %s: ns=%0d sec=%0d expected ns=%0d sec=%0d", tag, act_ns, act_sec, exp_ns, exp_sec);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      tick(2);
      rst = 1'b0;
   endtask

   task automatic load_period(input logic [39:0] p);
      period_ld = 1'b1; period_in = p;
      tick(1);
      period_ld = 1'b0;
   endtask

   task automatic load_time(input longint unsigned sec, input longint unsigned ns_raw);
      time_ld = 1'b1; time_sec_in = 48'(sec); time_ns_in = 38'(ns_raw);
      tick(1);
      time_ld = 1'b0;
   endtask

   task automatic start_slew(input logic [39:0] off, input logic [31:0] cyc);
      adj_ld = 1'b1; adj_offset = off; adj_cycles = cyc;
      tick(1);
      adj_ld = 1'b0;
   endtask

   // scoreboard driver: predicts n edges from the current outputs
   task automatic sb_run(input int n, input longint unsigned step_raw);
      longint unsigned e_ns = tod_ns;
      longint unsigned e_sec = tod_sec;
      for (int i = 0; i < n; i++) begin
         exp_t item;
         e_ns = e_ns + step_raw;
         if (e_ns >= longint'(wrap_ns)) begin
            e_ns = e_ns - longint'(wrap_ns);
            e_sec = e_sec + 1;
         end
         item.ns = e_ns; item.sec = e_sec;
         sb_q.push_back(item);
      end
      while (sb_q.size() != 0) @(negedge clk);
   endtask

   // scoreboard monitor: compares one item per edge, away from the edge
   initial forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() != 0) begin
         exp_t it;
         it = sb_q.pop_front();
         chk("R3 scoreboard per-cycle advance", tod_ns, tod_sec, it.ns, it.sec);
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: run did not finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      longint unsigned b_ns, b_sec;
      tick(3);
      chk("R1 outputs zero in reset", tod_ns, tod_sec, 0, 0);
      rst = 1'b0;
      tick(10);
      chk("R1 no advance without period", tod_ns, tod_sec, 0, 0);

      load_time(10, (NSEC - 100) * LSB);
      chk("R4 time load", tod_ns, tod_sec, (NSEC - 100) * LSB, 10);
      tick(5);
      chk("R1 still frozen after time load", tod_ns, tod_sec, (NSEC - 100) * LSB, 10);

      load_period({8'd8, 32'h0});
      chk("R2 load edge uses old period", tod_ns, tod_sec, (NSEC - 100) * LSB, 10);
      tick(12);
      chk("R2 advance by period", tod_ns, tod_sec, (NSEC - 4) * LSB, 10);
      tick(1);
      chk("R3 wrap past modulo", tod_ns, tod_sec, 4 * LSB, 11);

      load_time(20, (NSEC - 16) * LSB);
      chk("R4 load wins over increment", tod_ns, tod_sec, (NSEC - 16) * LSB, 20);
      tick(2);
      chk("R3 wrap at exact modulo", tod_ns, tod_sec, 0, 21);

      // short wrap value: many seconds carries
      wrap_ns = 38'(64'd1000 * LSB);
      sb_run(400, 8 * LSB);
      load_period({8'd7, 32'h0});
      sb_run(700, 7 * LSB);
      b_ns = tod_ns; b_sec = tod_sec;
      tick(1000);
      chk("R3 seven carries over 1000 edges", tod_ns, tod_sec, b_ns, b_sec + 7);

      // fraction reduction
      do_reset();
      wrap_ns = 38'(NSEC * LSB);
      load_period({8'd8, 32'h1080_0000});
      load_time(5, 100 * LSB);
      tick(200);
      chk("R5 average rate over 200 edges", tod_ns, tod_sec, 100 * LSB + 200 * 2064 + 100, 5);
      tick(1);
      chk("R5 carry edge", tod_ns, tod_sec, 100 * LSB + 200 * 2064 + 100 + 2065, 5);
      tick(1);
      chk("R5 no-carry edge", tod_ns, tod_sec, 100 * LSB + 200 * 2064 + 100 + 2065 + 2064, 5);

      // slewing
      do_reset();
      load_period({8'd8, 32'h0});
      start_slew({8'd5, 32'h0}, 32'd0);
      b_ns = tod_ns;
      tick(10);
      chk("R8 zero count adds nothing", tod_ns, tod_sec, b_ns + 10 * 8 * LSB, 0);

      start_slew({8'd2, 32'h0}, 32'd10);
      b_ns = tod_ns;
      tick(5);
      chk("R6 offset applied mid slew", tod_ns, tod_sec, b_ns + 5 * 10 * LSB, 0);
      tick(25);
      chk("R6 extra equals offset times count", tod_ns, tod_sec, b_ns + (30 * 8 + 2 * 10) * LSB, 0);

      start_slew({8'd0, 32'h4000_0000}, 32'd8);
      b_ns = tod_ns;
      tick(20);
      chk("R6 fractional offset", tod_ns, tod_sec, b_ns + 20 * 8 * LSB + 8 * 64, 0);

      start_slew({8'd1, 32'h0}, 32'd100);
      b_ns = tod_ns;
      tick(5);
      start_slew({8'd3, 32'h0}, 32'd4);
      tick(20);
      chk("R7 restrobe replaces count and offset", tod_ns, tod_sec, b_ns + 26 * 8 * LSB + (6 * 1 + 4 * 3) * LSB, 0);
      tick(10);
      chk("R7 no leftover after replacement", tod_ns, tod_sec, b_ns + 36 * 8 * LSB + 18 * LSB, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule